// File: doc/BRIEF.md
# Sequenced Booth Signed Multiplier

This block forms the full-width signed product of two two's-complement operands. A one-cycle start strobe captures the multiplier and the multiplicand. A small sequencer then walks the multiplier one radix-2 Booth digit per clock. Each digit selects the multiplicand, its negation, or nothing as that step's partial product. The partial product is folded into a sum/carry pair by a row of full-adder cells, so no carry ripples during accumulation.

After the last digit, one extra cycle runs a single carry-propagate add that merges the two vectors into the product register. In that same cycle a one-cycle completion pulse is raised. The pulse is intended to drive surrounding mode-switching logic. The product stays on the output until the next operation completes.

Operand width is a parameter (default 32, giving a 64-bit product). The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `booth_seq_mul`

## Requirements
- R1: `product_o` equals the exact signed product of `mplier_i` (multiplier) and `mcand_i` (multiplicand), both two's complement, as a 2*WIDTH-bit two's-complement value.
- R2: Corner operands give exact results: the most negative value times itself gives +2^(2*WIDTH-2), the most negative value times -1 gives +2^(WIDTH-1), and any operand times zero gives zero.
- R3: Multiplier bit pairs (bit i, bit i-1), with an implied bit -1 of 0, are recoded as follows: 01 adds the multiplicand shifted left by i, 10 subtracts it, and 00 and 11 add nothing. Operands made of long runs of equal bits therefore give correct results.
- R4: With `start_i` sampled high at rising edge E0 while idle, `done_o` is high exactly after edge E(WIDTH+1). That is WIDTH accumulation cycles and one resolve cycle.
- R5: `done_o` is high for exactly one clock cycle per accepted operation.
- R6: `product_o` changes only on the edge that raises `done_o`, and otherwise holds its value.
- R7: A `start_i` pulse while an operation is in progress is ignored. The running result is unchanged and no extra `done_o` pulse occurs.
- R8: While reset is asserted and after its release, `done_o` is low and `product_o` is zero. A reset during an operation aborts it without a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| mplier_i | input | WIDTH | Signed multiplier operand |
| mcand_i | input | WIDTH | Signed multiplicand operand |
| product_o | output | 2*WIDTH | Signed product, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 32 and covers the timing, pulse, hold, busy-start and reset scenarios, plus 64-bit corner products and pseudo-random operands. The second uses WIDTH set to 4. That size makes every one of the 256 operand pairs reachable, so every recoding pattern and every sign combination, including the most negative value squared, is checked against an independent product.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ACCUM   = 2'd1,
    SEQ_RESOLVE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PP_ZERO = 2'd0,
    PP_ADD  = 2'd1,
    PP_SUB  = 2'd2
  } pp_op_e;

endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
#(
  parameter int PW = 64
) (
  input  logic          bit_cur,
  input  logic          bit_prev,
  input  logic [PW-1:0] mcand_shifted,
  output pp_op_e        op,
  output logic [PW-1:0] pp,
  output logic          pp_cin
);

  // Radix-2 digit: pair 01 -> +M, 10 -> -M, 00/11 -> 0
  always_comb begin
    unique case ({bit_cur, bit_prev})
      2'b01:   op = PP_ADD;
      2'b10:   op = PP_SUB;
      default: op = PP_ZERO;
    endcase
  end

  // Negation is one's complement here plus a carry-in supplied downstream
  always_comb begin
    unique case (op)
      PP_ADD:  pp = mcand_shifted;
      PP_SUB:  pp = ~mcand_shifted;
      default: pp = '0;
    endcase
    pp_cin = (op == PP_SUB);
  end

endmodule

// File: rtl/booth_csa_row.sv
module booth_csa_row #(
  parameter int PW = 64
) (
  input  logic [PW-1:0] in_a,
  input  logic [PW-1:0] in_b,
  input  logic [PW-1:0] in_c,
  input  logic          cin,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] carry_o
);

  logic [PW-1:0] maj;

  // One full-adder cell per bit position
  for (genvar g = 0; g < PW; g++) begin : g_fa
    assign sum_o[g] = in_a[g] ^ in_b[g] ^ in_c[g];
    assign maj[g]   = (in_a[g] & in_b[g]) | (in_a[g] & in_c[g]) | (in_b[g] & in_c[g]);
  end

  // Carries move up one weight; the vacant LSB takes the injected carry-in
  assign carry_o = {maj[PW-2:0], cin};

endmodule

// File: rtl/booth_sequencer.sv
module booth_sequencer
  import booth_mul_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic resolve_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_ACCUM;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SEQ_ACCUM: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = SEQ_RESOLVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_RESOLVE: state_d = SEQ_IDLE;
      default:     state_d = SEQ_IDLE;
    endcase
    done_d = (state_q == SEQ_RESOLVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign load_o    = (state_q == SEQ_IDLE) && start_i;
  assign step_o    = (state_q == SEQ_ACCUM);
  assign resolve_o = (state_q == SEQ_RESOLVE);
  assign busy_o    = (state_q != SEQ_IDLE);
  assign done_o    = done_q;

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_follows_resolve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state_q) == SEQ_RESOLVE);

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ACCUM && cnt_q != LAST && start_i) |=> state_q == SEQ_ACCUM);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> cnt_q <= LAST);

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mplier_i,
  input  logic [WIDTH-1:0]   mcand_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               done_o
);

  localparam int PW = 2 * WIDTH;

  logic rst_sync_n;
  logic load, step, resolve, busy;

  logic [WIDTH-1:0] a_hold_q, b_hold_q;
  logic [WIDTH-1:0] mq_q, mq_d;
  logic             mq_prev_q, mq_prev_d;
  logic [PW-1:0]    mcand_q, mcand_d;
  logic [PW-1:0]    acc_s_q, acc_s_d;
  logic [PW-1:0]    acc_c_q, acc_c_d;
  logic [PW-1:0]    prod_q, prod_d;
  logic             dp_en;

  pp_op_e        op;
  logic [PW-1:0] pp;
  logic          pp_cin;
  logic [PW-1:0] row_sum, row_carry;

  booth_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  booth_sequencer #(.STEPS(WIDTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .load_o    (load),
    .step_o    (step),
    .resolve_o (resolve),
    .busy_o    (busy),
    .done_o    (done_o)
  );

  booth_recoder #(.PW(PW)) u_recoder (
    .bit_cur       (mq_q[0]),
    .bit_prev      (mq_prev_q),
    .mcand_shifted (mcand_q),
    .op            (op),
    .pp            (pp),
    .pp_cin        (pp_cin)
  );

  booth_csa_row #(.PW(PW)) u_csa (
    .in_a    (acc_s_q),
    .in_b    (acc_c_q),
    .in_c    (pp),
    .cin     (pp_cin),
    .sum_o   (row_sum),
    .carry_o (row_carry)
  );

  // Next-state of the datapath
  always_comb begin
    mq_d      = mq_q;
    mq_prev_d = mq_prev_q;
    mcand_d   = mcand_q;
    acc_s_d   = acc_s_q;
    acc_c_d   = acc_c_q;
    dp_en     = 1'b0;
    if (load) begin
      dp_en     = 1'b1;
      mq_d      = mplier_i;
      mq_prev_d = 1'b0;
      mcand_d   = {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
      acc_s_d   = '0;
      acc_c_d   = '0;
    end else if (step) begin
      dp_en     = 1'b1;
      mq_d      = {mq_q[WIDTH-1], mq_q[WIDTH-1:1]};
      mq_prev_d = mq_q[0];
      mcand_d   = {mcand_q[PW-2:0], 1'b0};
      acc_s_d   = row_sum;
      acc_c_d   = row_carry;
    end
    prod_d = acc_s_q + acc_c_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_hold_q <= '0;
      b_hold_q <= '0;
    end else if (load) begin
      a_hold_q <= mplier_i;
      b_hold_q <= mcand_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mq_q      <= '0;
      mq_prev_q <= 1'b0;
      mcand_q   <= '0;
      acc_s_q   <= '0;
      acc_c_q   <= '0;
    end else if (dp_en) begin
      mq_q      <= mq_d;
      mq_prev_q <= mq_prev_d;
      mcand_q   <= mcand_d;
      acc_s_q   <= acc_s_d;
      acc_c_q   <= acc_c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_q <= '0;
    end else if (resolve) begin
      prod_q <= prod_d;
    end
  end

  assign product_o = prod_q;

  assert_product_exact_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> product_o == ($signed({{WIDTH{a_hold_q[WIDTH-1]}}, a_hold_q}) *
                             $signed({{WIDTH{b_hold_q[WIDTH-1]}}, b_hold_q})));

  assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> $stable(product_o));

  assert_operands_kept_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start_i) |=> $stable(a_hold_q) && $stable(b_hold_q));

  assert_recode_legal_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step |-> (op != PP_SUB || mq_prev_q == 1'b0));

endmodule

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;

  localparam int W  = 32;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0]   mplier_i = '0, mcand_i = '0;
  logic [2*W-1:0] product_o;
  logic           done_o;

  logic start_n = 1'b0;
  logic [WN-1:0]   mplier_n = '0, mcand_n = '0;
  logic [2*WN-1:0] product_n;
  logic            done_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_seq_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mplier_i(mplier_i),
    .mcand_i(mcand_i), .product_o(product_o), .done_o(done_o));

  booth_seq_mul #(.WIDTH(WN)) dut_narrow_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_n), .mplier_i(mplier_n),
    .mcand_i(mcand_n), .product_o(product_n), .done_o(done_n));

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One wide operation; optionally a second start is pulsed mid-run
  task automatic run_wide(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject,
                          input string req);
    longint exp;
    logic [2*W-1:0] got;
    int lat, pulses;
    exp = longint'($signed(a)) * longint'($signed(b));
    lat = -1; pulses = 0; got = '0;
    @(negedge clk);
    mplier_i = a; mcand_i = b; start_i = 1'b1;
    for (int k = 1; k <= W + 8; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (inject && k == 10) begin start_i = 1'b1; mplier_i = 32'h0000_1234; mcand_i = 32'h0000_0777; end
      if (inject && k == 11) start_i = 1'b0;
      if (done_o) begin
        pulses++;
        if (lat < 0) begin lat = k; got = product_o; end
      end
    end
    check(got == 64'(exp), req, longint'(got), exp);
    check(lat == W + 2, "R4 latency", longint'(lat), longint'(W + 2));
    check(pulses == 1, "R5 single done pulse", longint'(pulses), 1);
    check(product_o == got, "R6 product held", longint'(product_o), longint'(got));
  endtask

  task automatic test_reset_state();
    check(done_o == 1'b0, "R8 done low after reset", longint'(done_o), 0);
    check(product_o == '0, "R8 product zero after reset", longint'(product_o), 0);
  endtask

  task automatic test_corners();
    run_wide(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 min*min");
    run_wide(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R2 min*-1");
    run_wide(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R2 max*min");
    run_wide(32'h0000_0000, 32'hDEAD_BEEF, 1'b0, "R2 zero*x");
    run_wide(32'h1357_9BDF, 32'h0000_0000, 1'b0, "R2 x*zero");
    run_wide(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R1 max*max");
  endtask

  task automatic test_recoding_runs();
    run_wide(32'h0FF0_0FF0, 32'h0000_0003, 1'b0, "R3 runs of ones");
    run_wide(32'hAAAA_AAAA, 32'hFFFF_FFF9, 1'b0, "R3 alternating bits");
    run_wide(32'hFFFF_FFFF, 32'h1234_5678, 1'b0, "R3 all ones");
    run_wide(32'h5555_5555, 32'h8765_4321, 1'b0, "R3 alternating odd");
  endtask

  task automatic test_random();
    for (int i = 0; i < 12; i++) begin
      run_wide($urandom(), $urandom(), 1'b0, "R1 random operands");
    end
  endtask

  task automatic test_busy_start();
    run_wide(32'hFEDC_BA98, 32'h0246_8ACE, 1'b1, "R7 busy start ignored");
  endtask

  task automatic test_reset_abort();
    int pulses;
    pulses = 0;
    @(negedge clk);
    mplier_i = 32'h0000_0055; mcand_i = 32'h0000_0033; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(done_o == 1'b0 && product_o == '0, "R8 state during reset",
          longint'(product_o), 0);
    rst_n = 1'b1;
    for (int k = 0; k < W + 8; k++) begin
      @(negedge clk);
      if (done_o) pulses++;
    end
    check(pulses == 0, "R8 aborted op gives no done", longint'(pulses), 0);
    check(product_o == '0, "R8 product zero after abort", longint'(product_o), 0);
    run_wide(32'hFFFF_FF85, 32'h0000_0101, 1'b0, "R8 normal op after abort");
  endtask

  task automatic test_narrow_exhaustive();
    int bad;
    int lat;
    logic [2*WN-1:0] got;
    int first_a, first_b;
    bad = 0; first_a = 0; first_b = 0;
    for (int a = 0; a < (1 << WN); a++) begin
      for (int b = 0; b < (1 << WN); b++) begin
        int ea, eb;
        logic [WN-1:0] av, bv;
        av = WN'(a); bv = WN'(b);
        ea = $signed(av); eb = $signed(bv);
        lat = -1; got = '0;
        @(negedge clk);
        mplier_n = av; mcand_n = bv; start_n = 1'b1;
        for (int k = 1; k <= WN + 3; k++) begin
          @(negedge clk);
          if (k == 1) start_n = 1'b0;
          if (done_n && lat < 0) begin lat = k; got = product_n; end
        end
        if (got != (2*WN)'(ea * eb) || lat != WN + 2) begin
          if (bad == 0) begin first_a = a; first_b = b; end
          bad++;
        end
        checks++;
        if (got != (2*WN)'(ea * eb)) begin
          errors++;
          $display("FAIL R1/R3 narrow %0d*%0d: got %0h expected %0h", ea, eb, got,
                   (2*WN)'(ea * eb));
        end
      end
    end
    check(bad == 0, "R4 narrow exhaustive latency/value", longint'(first_a * 16 + first_b), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset_state();
    test_corners();
    test_recoding_runs();
    test_random();
    test_busy_start();
    test_reset_abort();
    test_narrow_exhaustive();
    summary();
  end

endmodule